// File: doc/BRIEF.md
# Transmit Pause Countdown Timer

This block keeps the count of a flow-control pause request and tells the transmitter whether it may begin a new frame. When a received pause request is recognised, the detector strobes a load with a 16-bit count. The count is written regardless of what the register held and regardless of configuration. While pausing is enabled and the count is non-zero, the block raises a transmit-inhibit output. A frame that is already on the wire is not cut short; the inhibit only gates new starts.

The count steps down by one for every quantum of bit times, 512 by default. A bit-time tick feeds a prescaler for this. With pausing enabled, counting waits until the transmitter reports idle. With pausing disabled, counting runs whatever the transmitter is doing. A test-mode bit swaps the quantum prescaler for a receive-clock tick, so the count drops once per receive clock cycle. When a decrement takes the count to zero, a one-cycle interrupt pulse is produced if its mask bit allows it.

Top module: `pause_countdown`

## Requirements
- R1: A load strobe writes the supplied value into the count on the next clock edge, whatever the previous count and whatever the pause-enable bit.
- R2: The transmit-inhibit output is 1 exactly when pause-enable is 1 and the count is non-zero.
- R3: Outside test mode, the count drops by one after QUANTUM bit-time ticks taken while counting is allowed. With pause-enable 1, counting is allowed only while the transmitter-idle input is 1; ticks that arrive while the transmitter is busy neither advance the prescaler nor change the count.
- R4: In test mode, each receive-clock tick taken while counting is allowed lowers the count by one, and bit-time ticks have no effect.
- R5: With pause-enable 0, the count decrements whether the transmitter-idle input is 1 or 0.
- R6: A decrement that takes the count from 1 to 0 makes the interrupt output 1 for exactly one cycle, on the same edge where the count becomes 0, provided the mask input is 1; with the mask at 0 no pulse appears.
- R7: The count never goes below zero, and loading a value of zero produces no interrupt.
- R8: Every load restarts the bit-time prescaler, so a full QUANTUM ticks are needed after a load before the next decrement.
- R9: When a load and a decrement fall in the same cycle, the loaded value wins.
- R10: After reset the count is 0, the inhibit output is 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Strobe: write load_val_i into the count |
| load_val_i | input | CNT_W | Pause count from the detector |
| pause_en_i | input | 1 | Pause enable configuration bit |
| test_mode_i | input | 1 | 1 selects receive-clock tick as decrement source |
| tx_idle_i | input | 1 | 1 when no frame is being transmitted |
| bit_tick_i | input | 1 | One pulse per bit time |
| rx_tick_i | input | 1 | One pulse per receive clock cycle |
| irq_mask_i | input | 1 | 1 enables the zero-reached interrupt |
| tx_inhibit_o | output | 1 | 1 forbids starting a new frame |
| count_o | output | CNT_W | Current pause count |
| zero_irq_o | output | 1 | One-cycle pulse when the count is decremented to zero |

## Verification
The bench builds the block with an 8-bit count and a quantum of 4 bit times, and drives the bit and receive ticks directly as pulses. The short quantum lets a single test walk a count through several decrements, the prescaler restart on reload and the zero floor in a few dozen cycles. The 8-bit width keeps the load values easy to read. The power-of-two quantum selects the wrapping prescaler variant.

// File: rtl/pause_tmr_pkg.sv
package pause_tmr_pkg;

   // Which event may lower the count in a given cycle
   typedef enum logic [1:0] {
      DEC_NONE    = 2'd0,
      DEC_QUANTUM = 2'd1,
      DEC_RXCLK   = 2'd2
   } dec_src_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
   parameter int unsigned QUANTUM = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic adv_i,
   output logic step_o
);
   import pause_tmr_pkg::*;

   localparam int unsigned PW = (QUANTUM > 1) ? $clog2(QUANTUM) : 1;

   if (QUANTUM < 2) begin : g_bad_quantum
      $error("ptmr_prescaler: QUANTUM must be at least 2");
   end

   logic [PW-1:0] phase_q;

   if (is_pow2(QUANTUM)) begin : g_wrap
      // Power of two: the phase wraps on its own
      assign step_o = adv_i && (&phase_q) && !clear_i;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       phase_q <= '0;
         else if (clear_i) phase_q <= '0;
         else if (adv_i)   phase_q <= phase_q + 1'b1;
      end
   end else begin : g_cmp
      localparam logic [PW-1:0] LAST = PW'(QUANTUM - 1);
      assign step_o = adv_i && (phase_q == LAST) && !clear_i;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       phase_q <= '0;
         else if (clear_i) phase_q <= '0;
         else if (step_o)  phase_q <= '0;
         else if (adv_i)   phase_q <= phase_q + 1'b1;
      end
   end

   // R8: a clear always leaves the phase at its start
   a_r8_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (phase_q == '0));

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             nonzero_o,
   output logic             hit_zero_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("ptmr_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign nonzero_o  = (cnt_q != '0);
   assign hit_zero_o = dec_i && !load_i && (cnt_q == ONE);
   assign cnt_o      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (load_i)             cnt_q <= load_val_i;
      else if (dec_i && nonzero_o) cnt_q <= cnt_q - 1'b1;
   end

   // R1 / R9: a load is taken no matter what else happens
   a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val_i)));

   // R7: without a load the count only holds or steps down by one
   a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && nonzero_o) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1)));

   a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !nonzero_o) |=> (cnt_q == '0));

endmodule

// File: rtl/pause_countdown.sv
module pause_countdown #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned QUANTUM = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             pause_en_i,
   input  logic             test_mode_i,
   input  logic             tx_idle_i,
   input  logic             bit_tick_i,
   input  logic             rx_tick_i,
   input  logic             irq_mask_i,
   output logic             tx_inhibit_o,
   output logic [CNT_W-1:0] count_o,
   output logic             zero_irq_o
);
   import pause_tmr_pkg::*;

   logic     count_ok;
   logic     nonzero;
   logic     presc_adv;
   logic     presc_step;
   logic     dec;
   logic     hit_zero;
   logic     irq_q;
   dec_src_e src;

   // Enabled pausing waits for the transmitter; disabled pausing never waits
   assign count_ok  = (!pause_en_i || tx_idle_i) && nonzero;
   assign presc_adv = count_ok && !test_mode_i && bit_tick_i;

   always_comb begin
      if (!count_ok)        src = DEC_NONE;
      else if (test_mode_i) src = DEC_RXCLK;
      else                  src = DEC_QUANTUM;
   end

   always_comb begin
      unique case (src)
         DEC_QUANTUM: dec = presc_step;
         DEC_RXCLK:   dec = rx_tick_i;
         default:     dec = 1'b0;
      endcase
   end

   ptmr_prescaler #(.QUANTUM(QUANTUM)) presc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (load_i),
      .adv_i   (presc_adv),
      .step_o  (presc_step)
   );

   ptmr_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_val_i (load_val_i),
      .dec_i      (dec),
      .cnt_o      (count_o),
      .nonzero_o  (nonzero),
      .hit_zero_o (hit_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= hit_zero && irq_mask_i;
   end

   assign zero_irq_o   = irq_q;
   assign tx_inhibit_o = pause_en_i && nonzero;

   // R1: the loaded value shows on the count one edge later
   a_r1_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (count_o == $past(load_val_i)));

   // R3: an enabled pause with a busy transmitter freezes the count
   a_r3_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_en_i && !tx_idle_i && !load_i) |=> $stable(count_o));

   // R4: in test mode only a receive tick can move the count
   a_r4_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode_i && !rx_tick_i && !load_i) |=> $stable(count_o));

   // R6: the interrupt pulse coincides with a 1-to-0 step and was unmasked
   a_r6_irq_origin: assert property (@(posedge clk) disable iff (!rst_n)
      zero_irq_o |-> ((count_o == '0) && ($past(count_o) == CNT_W'(1)) && $past(irq_mask_i)));

   // R6: the pulse lasts a single cycle
   a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      zero_irq_o |=> !zero_irq_o);

endmodule

// File: tb/pause_countdown_tb_top.sv
module pause_countdown_tb_top;
   localparam int unsigned W = 8;
   localparam int unsigned Q = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_i = 1'b0;
   logic [W-1:0] load_val_i = '0;
   logic         pause_en_i = 1'b0;
   logic         test_mode_i = 1'b0;
   logic         tx_idle_i = 1'b0;
   logic         bit_tick_i = 1'b0;
   logic         rx_tick_i = 1'b0;
   logic         irq_mask_i = 1'b0;
   logic         tx_inhibit_o;
   logic [W-1:0] count_o;
   logic         zero_irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pause_countdown #(.CNT_W(W), .QUANTUM(Q)) dut_i (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
      .pause_en_i(pause_en_i), .test_mode_i(test_mode_i), .tx_idle_i(tx_idle_i),
      .bit_tick_i(bit_tick_i), .rx_tick_i(rx_tick_i), .irq_mask_i(irq_mask_i),
      .tx_inhibit_o(tx_inhibit_o), .count_o(count_o), .zero_irq_o(zero_irq_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // All stimulus changes at the falling edge
   task automatic load(input int v);
      load_i = 1'b1; load_val_i = W'(v);
      @(negedge clk);
      load_i = 1'b0;
   endtask

   task automatic bits(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick_i = 1'b1;
         @(negedge clk);
         bit_tick_i = 1'b0;
      end
   endtask

   task automatic rxs(input int n);
      for (int i = 0; i < n; i++) begin
         rx_tick_i = 1'b1;
         @(negedge clk);
         rx_tick_i = 1'b0;
      end
   endtask

   task automatic t_reset;
      chk("R10 count", count_o, 0);
      chk("R10 inhibit", tx_inhibit_o, 0);
      chk("R10 irq", zero_irq_o, 0);
   endtask

   task automatic t_load;
      pause_en_i = 1'b1; tx_idle_i = 1'b0;
      load(8'h55);
      chk("R1 load enabled", count_o, 8'h55);
      chk("R2 inhibit on", tx_inhibit_o, 1);
      pause_en_i = 1'b0;
      load(8'h12);
      chk("R1 overwrite disabled", count_o, 8'h12);
      chk("R2 inhibit off when disabled", tx_inhibit_o, 0);
   endtask

   task automatic t_busy_hold;
      pause_en_i = 1'b1; tx_idle_i = 1'b0;
      bits(2 * Q);
      chk("R3 busy hold", count_o, 8'h12);
   endtask

   task automatic t_normal;
      pause_en_i = 1'b1; tx_idle_i = 1'b1; irq_mask_i = 1'b0;
      load(3);
      bits(Q - 1);
      chk("R3 before quantum", count_o, 3);
      bits(1);
      chk("R3 after quantum", count_o, 2);
      bits(2 * Q);
      chk("R6 masked reach zero", count_o, 0);
      chk("R6 masked no irq", zero_irq_o, 0);
      chk("R2 inhibit clears at zero", tx_inhibit_o, 0);
      bits(Q);
      chk("R7 floor", count_o, 0);
   endtask

   task automatic t_irq;
      pause_en_i = 1'b1; tx_idle_i = 1'b1; irq_mask_i = 1'b1;
      load(1);
      bits(Q);
      chk("R6 irq pulse", zero_irq_o, 1);
      chk("R6 count at pulse", count_o, 0);
      @(negedge clk);
      chk("R6 irq one cycle", zero_irq_o, 0);
      load(0);
      chk("R7 zero load no irq", zero_irq_o, 0);
      @(negedge clk);
      chk("R7 zero load no irq later", zero_irq_o, 0);
   endtask

   task automatic t_test_mode;
      test_mode_i = 1'b1; pause_en_i = 1'b1; tx_idle_i = 1'b1; irq_mask_i = 1'b0;
      load(5);
      bits(Q);
      chk("R4 bit ticks ignored", count_o, 5);
      rxs(2);
      chk("R4 rx ticks", count_o, 3);
      tx_idle_i = 1'b0;
      rxs(1);
      chk("R4 rx busy hold", count_o, 3);
      test_mode_i = 1'b0;
   endtask

   task automatic t_disabled;
      pause_en_i = 1'b0; tx_idle_i = 1'b0;
      load(2);
      bits(Q);
      chk("R5 counts while busy", count_o, 1);
      chk("R2 no inhibit", tx_inhibit_o, 0);
   endtask

   task automatic t_restart;
      pause_en_i = 1'b1; tx_idle_i = 1'b1;
      load(5);
      bits(2);
      load(5);
      bits(Q - 2);
      chk("R8 restart no early step", count_o, 5);
      bits(2);
      chk("R8 step after full quantum", count_o, 4);
   endtask

   task automatic t_priority;
      pause_en_i = 1'b1; tx_idle_i = 1'b1; test_mode_i = 1'b1;
      load(5);
      rx_tick_i = 1'b1;
      load(9);
      rx_tick_i = 1'b0;
      chk("R9 load over rx step", count_o, 9);
      test_mode_i = 1'b0;
      load(7);
      bits(Q - 1);
      bit_tick_i = 1'b1;
      load(6);
      bit_tick_i = 1'b0;
      chk("R9 load over quantum step", count_o, 6);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_busy_hold();
      t_normal();
      t_irq();
      t_test_mode();
      t_disabled();
      t_restart();
      t_priority();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (R1..R10 sequence): actual=timeout expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule